// File: doc/BRIEF.md
# Binary-Counting Pulse Width-Density Modulator

This block turns an unsigned N-bit code into a one-bit pulse stream. Averaged over one frame, the stream is proportional to the code. A free-running N-bit counter defines frames of 2^N clock cycles. Each input bit k selects the first interval in the frame where counter bit k is high. That interval begins at count 2^k and lasts 2^k cycles. The selected intervals are merged into a single output.

A plain PWM output would give one wide pulse. This block gives several binary-weighted sub-pulses spread across the frame, with the same mean. An external low-pass filter turns the stream into a voltage. The code is sampled once per frame, at the counter wrap. A strobe marks the first output cycle of every frame. An enable input pauses the frame and forces the output low.

Top module: `pwd_modulator`

## Requirements
- R1: A frame is exactly 2^N enabled clock cycles. `frame_start_o` is high for one cycle per frame: the output cycle that corresponds to count 0. It is low during the other 2^N−1 enabled cycles of the frame.
- R2: Let position p be the number of enabled cycles since the strobe (p = 1 … 2^N−1). Then `pwdm_o` at position p equals bit k of the held code, where k is the index of the most significant set bit of p. So bit 0 covers position 1, bit 1 covers positions 2–3, and bit N−1 covers positions 2^(N−1) to 2^N−1.
- R3: The number of high output cycles in a frame equals the held code value. For example, code 173 gives 173 high cycles out of 256.
- R4: The output is low in the strobe cycle of every frame. The duty cycle therefore peaks at (2^N−1)/2^N, for code 2^N−1.
- R5: `code_i` is captured only on the clock edge where the counter wraps from 2^N−1 to 0. A change in mid-frame has no effect on the current frame and applies to the next one.
- R6: The output and the strobe are registered. Each one reflects the counter and held code of the previous cycle, which gives one cycle of latency.
- R7: While `en_i` is low, the counter holds its value. From the next cycle on, `pwdm_o` and `frame_start_o` are low. When enable returns, the frame resumes at the next position with no position skipped.
- R8: A synchronous reset clears the counter, the held code, the output and the strobe. The first frame after reset is therefore entirely low, whatever `code_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; when low, the frame is paused and the output is low |
| code_i | input | CODE_BITS | Unsigned code, sampled at the frame wrap |
| pwdm_o | output | 1 | Modulated pulse stream |
| frame_start_o | output | 1 | One-cycle marker of the first output cycle of a frame |

## Verification
If the counter is corrupted, the strobe spacing moves away from 2^N. The sub-pulses also shift from their binary-weighted positions, and this shows within one frame. If the held code is corrupted or loaded at the wrong time, the high-cycle count of the next complete frame changes. A mid-frame load shows at the first position after the change whose covering bit differs between the old and new codes. A fault in the enable path appears in the cycle after enable falls, as a non-zero output or a skipped or repeated position when the frame resumes.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    // Default resolution of the modulator code.
    localparam int unsigned DEFAULT_CODE_BITS = 8;

endpackage

// File: rtl/pwd_frame_counter.sv
module pwd_frame_counter #(
    parameter int unsigned CODE_BITS = pwd_pkg::DEFAULT_CODE_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_i,
    output logic [CODE_BITS-1:0] count_o,
    output logic                 wrap_o
);

    localparam logic [CODE_BITS-1:0] CNT_MAX = '1;
    localparam logic [CODE_BITS-1:0] CNT_ONE = CODE_BITS'(1);

    typedef struct packed {
        logic [CODE_BITS-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    // Next-state computation: advance only while enabled, wrap naturally.
    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.count = st_q.count + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign wrap_o  = en_i && (st_q.count == CNT_MAX);

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en_i && count_o == CNT_MAX) |=> (count_o == '0)); // R1

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (en_i && count_o != CNT_MAX) |=> (count_o == $past(count_o) + CNT_ONE)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(count_o)); // R7

endmodule

// File: rtl/pwd_pulse_select.sv
module pwd_pulse_select #(
    parameter int unsigned CODE_BITS = pwd_pkg::DEFAULT_CODE_BITS
) (
    input  logic [CODE_BITS-1:0] count_i,
    input  logic [CODE_BITS-1:0] code_i,
    output logic [CODE_BITS-1:0] hits_o,
    output logic                 pulse_o
);

    // Per bit: first high phase of counter bit k (all higher counter bits low),
    // gated by code bit k. Three levels: NOR of upper bits, AND, final OR.
    for (genvar k = 0; k < CODE_BITS; k++) begin : g_bit
        logic upper_clear;
        if (k == CODE_BITS - 1) begin : g_top
            assign upper_clear = 1'b1;
        end else begin : g_low
            assign upper_clear = ~|count_i[CODE_BITS-1:k+1];
        end
        assign hits_o[k] = code_i[k] & count_i[k] & upper_clear;
    end

    assign pulse_o = |hits_o;

endmodule

// File: rtl/pwd_modulator.sv
module pwd_modulator #(
    parameter int unsigned CODE_BITS = pwd_pkg::DEFAULT_CODE_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_i,
    input  logic [CODE_BITS-1:0] code_i,
    output logic                 pwdm_o,
    output logic                 frame_start_o
);

    typedef struct packed {
        logic [CODE_BITS-1:0] held;
        logic                 out;
        logic                 start;
    } mod_state_t;

    mod_state_t st_d, st_q;

    logic [CODE_BITS-1:0] count;
    logic                 wrap;
    logic [CODE_BITS-1:0] hits;
    logic                 pulse;

    pwd_frame_counter #(.CODE_BITS(CODE_BITS)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .count_o (count),
        .wrap_o  (wrap)
    );

    pwd_pulse_select #(.CODE_BITS(CODE_BITS)) u_select (
        .count_i (count),
        .code_i  (st_q.held),
        .hits_o  (hits),
        .pulse_o (pulse)
    );

    // Next-state computation: capture code at wrap, register output and strobe.
    always_comb begin
        st_d       = st_q;
        st_d.out   = en_i && pulse;
        st_d.start = en_i && (count == '0);
        if (wrap) begin
            st_d.held = code_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwdm_o        = st_q.out;
    assign frame_start_o = st_q.start;

    AST_LOW_AT_START: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> !pwdm_o); // R4

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(st_q.held)); // R5

    AST_CODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (st_q.held == $past(code_i))); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!pwdm_o && !frame_start_o)); // R7

    AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hits)); // R2

    AST_START_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en_i && count == '0) |=> frame_start_o); // R6

endmodule

// File: tb/pwd_modulator_bench.sv
`timescale 1ns/1ps
module pwd_modulator_bench;

    localparam int NB    = 8;
    localparam int FRAME = 1 << NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_i = 1'b0;
    logic [NB-1:0] code_i = '0;
    logic          pwdm_o;
    logic          frame_start_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pwd_modulator #(.CODE_BITS(NB)) u_pwd_modulator (
        .clk           (clk),
        .rst           (rst),
        .en_i          (en_i),
        .code_i        (code_i),
        .pwdm_o        (pwdm_o),
        .frame_start_o (frame_start_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic logic exp_bit(input logic [NB-1:0] c, input int p);
        int k = 0;
        for (int i = 0; i < NB; i++) begin
            if (p[i]) k = i;
        end
        return c[k];
    endfunction

    // Entered at the negedge showing position 0 of a frame. Walks positions
    // 1..FRAME-1 and ends at the negedge showing position 0 of the next frame.
    task automatic run_frame(input logic [NB-1:0] exp_code, input int pause_at,
                             input int pause_len, input int change_at,
                             input logic [NB-1:0] new_code, input string tag);
        int highs = 0;
        int bad_pos = 0;
        int first_bad = -1;
        int stray_start = 0;
        int idle_bad = 0;
        for (int p = 1; p < FRAME; p++) begin
            @(negedge clk);
            if (pwdm_o) highs++;
            if (pwdm_o !== exp_bit(exp_code, p)) begin
                bad_pos++;
                if (first_bad < 0) first_bad = p;
            end
            if (frame_start_o) stray_start++;
            if (p == change_at) code_i = new_code;
            if (p == pause_at) begin
                en_i = 1'b0;
                for (int i = 0; i < pause_len; i++) begin
                    @(negedge clk);
                    if (pwdm_o || frame_start_o) idle_bad++;
                end
                en_i = 1'b1;
            end
        end
        // R2: binary-weighted sub-pulse placement
        check(bad_pos == 0, {"R2 placement ", tag}, first_bad, -1);
        // R3: high-cycle count equals code
        check(highs == int'(exp_code), {"R3 high count ", tag}, highs, int'(exp_code));
        // R1: no strobe inside frame
        check(stray_start == 0, {"R1 stray strobe ", tag}, stray_start, 0);
        if (pause_len > 0) begin
            // R7: output and strobe low while paused, resume without skip (R2 above)
            check(idle_bad == 0, {"R7 idle output ", tag}, idle_bad, 0);
        end
        @(negedge clk);
        // R1, R6: strobe exactly 2^N enabled cycles after the previous one
        check(frame_start_o === 1'b1, {"R1 strobe period ", tag}, int'(frame_start_o), 1);
        // R4: output low at count 0
        check(pwdm_o === 1'b0, {"R4 low at start ", tag}, int'(pwdm_o), 0);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        en_i = 1'b1;
        code_i = 8'hFF;
        repeat (3) @(negedge clk);
        // R8: cleared state during reset
        check(pwdm_o === 1'b0, "R8 reset output", int'(pwdm_o), 0);
        check(frame_start_o === 1'b0, "R8 reset strobe", int'(frame_start_o), 0);
        rst = 1'b0;
        @(negedge clk);
        // R6: strobe registered one cycle after count 0
        check(frame_start_o === 1'b1, "R6 first strobe", int'(frame_start_o), 1);
    endtask

    initial begin
        test_reset();
        // R8: held code is zero in the first frame; R5: mid-frame change ignored
        run_frame(8'h00, -1, 0, 50, 8'd173, "R8 first frame");
        // Example code 1010_1101; change code at position 1 (R5)
        run_frame(8'd173, -1, 0, 1, 8'hFF, "code 173");
        // Full scale with a pause at the MSB region (R7); change mid-frame (R5)
        run_frame(8'hFF, 128, 5, 200, 8'h00, "full scale paused");
        run_frame(8'h00, -1, 0, 10, 8'h01, "zero code");
        run_frame(8'h01, 3, 2, 10, 8'h80, "lsb only paused");
        run_frame(8'h80, -1, 0, 10, 8'h5A, "msb only");
        run_frame(8'h5A, -1, 0, 255, 8'h00, "code 0x5A");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule